// File: doc/BRIEF.md
# Actuator Move and Homing Sequencer

This block decides how many drive periods a piezo actuator receives, in which direction, and when. A separate waveform generator shapes each period and raises `period_end` for one clock at every period boundary. It keeps doing so whether or not periods are being driven. The sequencer counts those boundaries and tells the generator whether to drive (`drive_run`) and in which direction (`drive_dir`). It also reports through `busy` that an operation is in progress.

The block runs only while the enable pin and the enable register bit are both high. When the second of the two becomes true, the block starts up. It then runs a homing routine unless the skip bit is set. Homing has three parts: it drives toward the commanded direction, pauses, and then swings back the opposite way. After startup, a write to the command register loads a pulse count and a direction. Each pulse lasts one step group of `cfg_step_count + 1` periods. Further writes in the same direction add to the pending count. A write in the other direction replaces the pending count.

States: `ST_OFF` (disabled), `ST_IDLE` (enabled, nothing pending), `ST_MOVE` (executing a command), `ST_HOME_DRIVE`, `ST_HOME_WAIT` and `ST_HOME_BACK` (the three homing parts).

Transitions:
- OFF→HOME_DRIVE: startup with the skip bit clear.
- OFF→IDLE: startup with the skip bit set.
- IDLE→MOVE: a write with a non-zero count.
- MOVE→IDLE: the count is exhausted, or a direction-change write carries a count of zero.
- HOME_DRIVE→HOME_WAIT, HOME_WAIT→HOME_BACK and HOME_BACK→IDLE: the current part's repetition count is exhausted.
- Any state→OFF: the block is disabled.

Top module: `piezo_move_seq`

## Requirements
- R1: The block is active only while `en_pin` and `cfg_enable` are both 1. Startup happens when the later of the two rises. Either one may rise last, and one of them alone starts nothing. Dropping either one forces `busy` and `drive_run` to 0 in the same cycle and discards any pending count.
- R2: At startup with `cfg_skip_home`=1 the block goes idle, with `busy`=0. With `cfg_skip_home`=0, homing begins on the next clock, with `busy`=1.
- R3: The first homing part drives (`drive_run`=1) in the direction given by the last command direction bit written. It lasts (`cfg_home_code`+1)×16×(`cfg_step_count`+1) periods.
- R4: The second homing part lasts 4×(`cfg_step_count`+1) periods, with `busy`=1 and `drive_run`=0.
- R5: The third homing part drives in the inverted direction for N×(`cfg_step_count`+1) periods. N is decoded from `cfg_ret_code` as 00→2, 01→1, 10→3 and 11→4. `busy` falls on the clock after the last period_end of this part.
- R6: When idle, a `cmd_wr` with `cmd_pulses`=n>0 raises `busy` and `drive_run` on the next clock, with `drive_dir`=`cmd_dir`. The move lasts exactly n×(`cfg_step_count`+1) periods. `busy` falls on the clock after the last one.
- R7: A write in the current direction adds its count to what remains. The total saturates at 512 pulses.
- R8: A write whose direction differs from the stored one replaces the remaining count with the new count and restarts the step group. A count of 0 stops the move on the next clock.
- R9: Pulse counts written while the block is disabled or homing are discarded. The direction bit of every write is still stored.
- R10: Periods are counted only on `period_end`. `period_end` pulses while idle have no effect on a later move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_pin | input | 1 | External enable |
| cfg_enable | input | 1 | Enable register bit |
| cfg_skip_home | input | 1 | 1 skips the homing routine |
| cfg_ret_code | input | 2 | Swing-back repetition code |
| cfg_home_code | input | 4 | Homing drive code, (code+1)×16 repetitions |
| cfg_step_count | input | 8 | Periods per pulse minus one |
| cmd_wr | input | 1 | One-cycle command register write strobe |
| cmd_dir | input | 1 | Command direction bit |
| cmd_pulses | input | 7 | Command pulse count, 0 to 127 |
| period_end | input | 1 | One-cycle pulse at each period boundary |
| drive_run | output | 1 | Drive periods now |
| drive_dir | output | 1 | Direction of driven periods |
| busy | output | 1 | Move or homing in progress |

## Verification
The bench sweeps every swing-back code, both homing drive codes, several step sizes and both directions. It compares `drive_run` and `drive_dir` at every single period, so a design that miscounted the pause (for example, stopping the count while not driving) would show a wrong phase boundary. A design with the swing-back table scrambled, or whose step counter is off by one, would shift where `busy` falls. Command accumulation is driven up to the 512-pulse ceiling. A direction change is made in the middle of a step group, which catches a design that keeps the old partial group. Enable drops in the middle of a move and writes made while disabled or homing expose a design that leaks a stale count into the next operation.

// File: rtl/piezo_seq_pkg.sv
package piezo_seq_pkg;
    typedef enum logic [2:0] {
        ST_OFF        = 3'd0,
        ST_IDLE       = 3'd1,
        ST_MOVE       = 3'd2,
        ST_HOME_DRIVE = 3'd3,
        ST_HOME_WAIT  = 3'd4,
        ST_HOME_BACK  = 3'd5
    } seq_state_e;
endpackage

// File: rtl/seq_phase_len.sv
module seq_phase_len #(
    parameter int CNT_W     = 10,
    parameter int HOME_W    = 4,
    parameter int RET_W     = 2,
    parameter int HOME_UNIT = 16,
    parameter int WAIT_REPS = 4
) (
    input  logic [HOME_W-1:0] home_code,
    input  logic [RET_W-1:0]  ret_code,
    output logic [CNT_W-1:0]  home_reps,
    output logic [CNT_W-1:0]  wait_reps,
    output logic [CNT_W-1:0]  back_reps
);
    logic [CNT_W-1:0] home_plus;

    always_comb begin
        home_plus = CNT_W'(home_code) + CNT_W'(1);
        home_reps = home_plus * CNT_W'(HOME_UNIT);
        wait_reps = CNT_W'(WAIT_REPS);
        unique case (ret_code)
            2'b00:   back_reps = CNT_W'(2);
            2'b01:   back_reps = CNT_W'(1);
            2'b10:   back_reps = CNT_W'(3);
            default: back_reps = CNT_W'(4);
        endcase
    end
endmodule

// File: rtl/seq_step_counter.sv
module seq_step_counter #(
    parameter int STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              advance,
    input  logic [STEP_W-1:0] limit,
    output logic              wrap
);
    logic [STEP_W-1:0] cnt;
    logic              at_end;

    assign at_end = (cnt >= limit);
    assign wrap   = advance && !clear && at_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (clear)   cnt <= '0;
        else if (advance) cnt <= at_end ? '0 : cnt + STEP_W'(1);
    end
endmodule

// File: rtl/piezo_move_seq.sv
module piezo_move_seq
    import piezo_seq_pkg::*;
#(
    parameter int STEP_W     = 8,
    parameter int PULSE_W    = 7,
    parameter int HOME_W     = 4,
    parameter int RET_W      = 2,
    parameter int MAX_PULSES = 512,
    parameter int HOME_UNIT  = 16,
    parameter int WAIT_REPS  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_pin,
    input  logic               cfg_enable,
    input  logic               cfg_skip_home,
    input  logic [RET_W-1:0]   cfg_ret_code,
    input  logic [HOME_W-1:0]  cfg_home_code,
    input  logic [STEP_W-1:0]  cfg_step_count,
    input  logic               cmd_wr,
    input  logic               cmd_dir,
    input  logic [PULSE_W-1:0] cmd_pulses,
    input  logic               period_end,
    output logic               drive_run,
    output logic               drive_dir,
    output logic               busy
);
    localparam int CNT_W = $clog2(MAX_PULSES + 1);
    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_PULSES);

    seq_state_e       state, state_n;
    logic [CNT_W-1:0] pend, pend_n, pend_dec, pend_add, cmd_ext;
    logic [CNT_W:0]   sum;
    logic             home_dir, home_dir_n, dir_reg;
    logic             active, counting, advance, wrap, wr_ok, dir_flip, clr;
    logic [CNT_W-1:0] home_reps, wait_reps, back_reps;

    assign active   = en_pin && cfg_enable;
    assign counting = active && (state == ST_MOVE || state == ST_HOME_DRIVE ||
                                 state == ST_HOME_WAIT || state == ST_HOME_BACK);
    assign advance  = period_end && counting;
    assign wr_ok    = active && cmd_wr && (state == ST_IDLE || state == ST_MOVE);
    assign dir_flip = wr_ok && (state == ST_MOVE) && (cmd_dir != dir_reg);
    assign clr      = !counting || dir_flip;

    seq_phase_len #(
        .CNT_W(CNT_W), .HOME_W(HOME_W), .RET_W(RET_W),
        .HOME_UNIT(HOME_UNIT), .WAIT_REPS(WAIT_REPS)
    ) u_len (
        .home_code(cfg_home_code),
        .ret_code (cfg_ret_code),
        .home_reps(home_reps),
        .wait_reps(wait_reps),
        .back_reps(back_reps)
    );

    seq_step_counter #(.STEP_W(STEP_W)) u_step (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clr),
        .advance(advance),
        .limit  (cfg_step_count),
        .wrap   (wrap)
    );

    // Pending-count arithmetic shared by the move states
    always_comb begin
        cmd_ext  = {{(CNT_W-PULSE_W){1'b0}}, cmd_pulses};
        pend_dec = (wrap && pend != '0) ? pend - CNT_W'(1) : pend;
        sum      = {1'b0, pend_dec} + {1'b0, cmd_ext};
        pend_add = (sum > {1'b0, MAX_C}) ? MAX_C : sum[CNT_W-1:0];
    end

    // Next-state process
    always_comb begin
        state_n    = state;
        pend_n     = pend;
        home_dir_n = home_dir;
        if (!active) begin
            state_n = ST_OFF;
            pend_n  = '0;
        end else begin
            unique case (state)
                ST_OFF: begin
                    if (cfg_skip_home) begin
                        state_n = ST_IDLE;
                        pend_n  = '0;
                    end else begin
                        state_n    = ST_HOME_DRIVE;
                        pend_n     = home_reps;
                        home_dir_n = dir_reg;
                    end
                end
                ST_IDLE: begin
                    if (wr_ok && cmd_ext != '0) begin
                        state_n = ST_MOVE;
                        pend_n  = cmd_ext;
                    end
                end
                ST_MOVE: begin
                    if (dir_flip)   pend_n = cmd_ext;
                    else if (wr_ok) pend_n = pend_add;
                    else            pend_n = pend_dec;
                    if (pend_n == '0) state_n = ST_IDLE;
                end
                ST_HOME_DRIVE: begin
                    if (wrap) begin
                        if (pend == CNT_W'(1)) begin
                            state_n = ST_HOME_WAIT;
                            pend_n  = wait_reps;
                        end else begin
                            pend_n = pend - CNT_W'(1);
                        end
                    end
                end
                ST_HOME_WAIT: begin
                    if (wrap) begin
                        if (pend == CNT_W'(1)) begin
                            state_n = ST_HOME_BACK;
                            pend_n  = back_reps;
                        end else begin
                            pend_n = pend - CNT_W'(1);
                        end
                    end
                end
                ST_HOME_BACK: begin
                    if (wrap) begin
                        if (pend == CNT_W'(1)) begin
                            state_n = ST_IDLE;
                            pend_n  = '0;
                        end else begin
                            pend_n = pend - CNT_W'(1);
                        end
                    end
                end
                default: begin
                    state_n = ST_OFF;
                    pend_n  = '0;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_OFF;
            pend     <= '0;
            home_dir <= 1'b0;
            dir_reg  <= 1'b0;
        end else begin
            state    <= state_n;
            pend     <= pend_n;
            home_dir <= home_dir_n;
            if (cmd_wr) dir_reg <= cmd_dir;
        end
    end

    // Output process
    always_comb begin
        busy      = 1'b0;
        drive_run = 1'b0;
        drive_dir = dir_reg;
        if (active) begin
            unique case (state)
                ST_MOVE:       begin busy = 1'b1; drive_run = 1'b1; end
                ST_HOME_DRIVE: begin busy = 1'b1; drive_run = 1'b1; drive_dir = home_dir; end
                ST_HOME_WAIT:  begin busy = 1'b1; end
                ST_HOME_BACK:  begin busy = 1'b1; drive_run = 1'b1; drive_dir = !home_dir; end
                default:       begin busy = 1'b0; end
            endcase
        end
    end

    assert_off_when_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (state == ST_OFF && pend == '0));

    assert_home_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF && active && !cfg_skip_home) |=> (state == ST_HOME_DRIVE));

    assert_wait_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (active && state == ST_HOME_DRIVE && wrap && pend == CNT_W'(1))
        |=> (state == ST_HOME_WAIT && pend == CNT_W'(WAIT_REPS)));

    assert_home_dir_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && (state == ST_HOME_WAIT || state == ST_HOME_BACK)) |=> $stable(home_dir));

    assert_move_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MOVE) |-> (pend != '0));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pend <= MAX_C);

    assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (active && state == ST_IDLE && !cmd_wr) |=> (state == ST_IDLE));
endmodule

// File: tb/tb_piezo_move_seq.sv
module tb_piezo_move_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_pin = 1'b0, cfg_enable = 1'b0, cfg_skip_home = 1'b1;
    logic [1:0] cfg_ret_code = '0;
    logic [3:0] cfg_home_code = '0;
    logic [7:0] cfg_step_count = '0;
    logic       cmd_wr = 1'b0, cmd_dir = 1'b0;
    logic [6:0] cmd_pulses = '0;
    logic       period_end = 1'b0;
    logic       drive_run, drive_dir, busy;
    int         vec = 0, bad = 0;

    always #5 clk = ~clk;

    piezo_move_seq dut (
        .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .cfg_enable(cfg_enable),
        .cfg_skip_home(cfg_skip_home), .cfg_ret_code(cfg_ret_code),
        .cfg_home_code(cfg_home_code), .cfg_step_count(cfg_step_count),
        .cmd_wr(cmd_wr), .cmd_dir(cmd_dir), .cmd_pulses(cmd_pulses),
        .period_end(period_end), .drive_run(drive_run), .drive_dir(drive_dir),
        .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic pulse;
        period_end = 1'b1;
        tick();
        period_end = 1'b0;
    endtask

    task automatic wr(input bit d, input int n);
        cmd_wr = 1'b1; cmd_dir = d; cmd_pulses = 7'(n);
        tick();
        cmd_wr = 1'b0;
    endtask

    function automatic int ret_n(input int c);
        case (c)
            0: return 2;
            1: return 1;
            2: return 3;
            default: return 4;
        endcase
    endfunction

    // Expect a move of len periods in direction d, then idle
    task automatic run_move(input int len, input bit d, input string req);
        for (int i = 0; i < len; i++) begin
            chk(busy && drive_run && drive_dir == d, req,
                {busy, drive_run, drive_dir}, {1'b1, 1'b1, d});
            pulse();
        end
        chk(!busy && !drive_run, req, {busy, drive_run}, 0);
    endtask

    task automatic enable_skip;
        en_pin = 1'b0; cfg_enable = 1'b0; tick();
        cfg_skip_home = 1'b1;
        en_pin = 1'b1; cfg_enable = 1'b1; tick();
        chk(!busy, "R2 skip start", busy, 0);
    endtask

    task automatic home_case(input int stp, input int hc, input int rc, input bit d,
                             input bit pin_first, input bit mid_write);
        int h, w, r;
        bit er, ed;
        en_pin = 1'b0; cfg_enable = 1'b0; tick();
        cfg_step_count = 8'(stp); cfg_home_code = 4'(hc); cfg_ret_code = 2'(rc);
        cfg_skip_home = 1'b0;
        wr(d, 0);
        if (pin_first) en_pin = 1'b1; else cfg_enable = 1'b1;
        tick();
        chk(!busy, "R1 one enable alone", busy, 0);
        en_pin = 1'b1; cfg_enable = 1'b1;
        tick();
        h = (hc + 1) * 16 * (stp + 1);
        w = 4 * (stp + 1);
        r = ret_n(rc) * (stp + 1);
        for (int i = 0; i < h + w + r; i++) begin
            er = (i < h) || (i >= h + w);
            ed = (i < h) ? d : !d;
            if (i < h)
                chk(busy && drive_run && drive_dir == ed, "R3 homing drive",
                    {busy, drive_run, drive_dir}, {1'b1, er, ed});
            else if (i < h + w)
                chk(busy && !drive_run, "R4 homing pause",
                    {busy, drive_run}, {1'b1, 1'b0});
            else
                chk(busy && drive_run && drive_dir == ed, "R5 swing back",
                    {busy, drive_run, drive_dir}, {1'b1, er, ed});
            if (mid_write && i == 5) wr(d, 9);
            pulse();
        end
        chk(!busy && !drive_run, mid_write ? "R9 write during homing" : "R5 end of homing",
            {busy, drive_run}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        tick(); tick();
        chk(!busy && !drive_run, "R1 reset state", {busy, drive_run}, 0);
        rst_n = 1'b1;
        tick();

        // R3 R4 R5: homing sweep
        for (int stp = 0; stp < 3; stp++)
            for (int hc = 0; hc < 2; hc++)
                for (int rc = 0; rc < 4; rc++)
                    for (int d = 0; d < 2; d++)
                        home_case(stp, hc, rc, d[0], (rc % 2) == 1, 1'b0);
        // R9: write during homing is discarded
        home_case(0, 0, 1, 1'b1, 1'b0, 1'b1);

        // R6: basic moves
        enable_skip();
        foreach (cfg_step_count[k]) ; // no-op keeps loop form simple
        for (int stp = 0; stp < 4; stp++) begin
            cfg_step_count = 8'(stp);
            for (int d = 0; d < 2; d++) begin
                wr(d[0], 1); run_move(1 * (stp + 1), d[0], "R6 move n=1");
                wr(d[0], 2); run_move(2 * (stp + 1), d[0], "R6 move n=2");
                wr(d[0], 5); run_move(5 * (stp + 1), d[0], "R6 move n=5");
            end
        end
        cfg_step_count = 8'd3;
        wr(1'b0, 127); run_move(127 * 4, 1'b0, "R6 move n=127");

        // R7: accumulate and saturate
        cfg_step_count = 8'd0;
        wr(1'b0, 3); pulse(); wr(1'b0, 4);
        run_move(6, 1'b0, "R7 accumulate");
        for (int k = 0; k < 5; k++) wr(1'b1, 127);
        run_move(512, 1'b1, "R7 saturate at 512");

        // R8: direction change replaces count, restarts step group
        wr(1'b0, 10); pulse(); pulse(); pulse(); wr(1'b1, 4);
        run_move(4, 1'b1, "R8 replace count");
        cfg_step_count = 8'd1;
        wr(1'b0, 3); pulse(); wr(1'b1, 2);
        run_move(4, 1'b1, "R8 restart step group");
        cfg_step_count = 8'd0;
        wr(1'b0, 10); pulse(); pulse(); wr(1'b1, 0);
        chk(!busy && !drive_run, "R8 stop by zero", {busy, drive_run}, 0);

        // R10: idle period_end pulses do not count
        for (int k = 0; k < 5; k++) pulse();
        chk(!busy, "R10 idle pulses", busy, 0);
        cfg_step_count = 8'd2;
        wr(1'b1, 2); run_move(6, 1'b1, "R10 move after idle pulses");

        // R1: drop enable mid-move
        cfg_step_count = 8'd0;
        wr(1'b0, 10); pulse(); pulse(); pulse();
        cfg_enable = 1'b0;
        #1;
        chk(!busy && !drive_run, "R1 immediate stop", {busy, drive_run}, 0);
        tick();
        cfg_enable = 1'b1; tick();
        chk(!busy, "R1 pending discarded", busy, 0);
        en_pin = 1'b0; #1;
        chk(!busy, "R1 pin drop", busy, 0);

        // R9: writes while disabled are discarded, direction kept
        tick();
        wr(1'b1, 20);
        en_pin = 1'b1; tick(); tick();
        chk(!busy, "R9 write while disabled", busy, 0);
        en_pin = 1'b0; cfg_enable = 1'b0; tick();
        cfg_skip_home = 1'b0; cfg_home_code = 4'd0; cfg_ret_code = 2'd1;
        wr(1'b1, 0);
        en_pin = 1'b1; cfg_enable = 1'b1; tick();
        chk(drive_dir == 1'b1 && drive_run, "R9 direction kept", drive_dir, 1);

        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule